// File: doc/BRIEF.md
# Host-to-Network-Processor Receive DMA Channel

This block is the receive half of a link between a host and a network message processor. The network side offers 32-bit words, each with an end-of-message marker. The channel writes each word into host memory through a simple write-request port. A nonexistent address makes that port answer with an error.

Software runs the channel through four 16-bit registers at byte offsets 0 (control/status), 2 (data buffer), 4 (current byte address) and 6 (word count). A write with the start bit set begins a transfer. A transfer ends when the word count reaches zero, when a word marked end-of-message is stored, or when an error occurs. At the end the channel goes ready again and, if enabled, raises an interrupt.

The channel also drives the relay that signals host readiness to the network side. It reports the debounced host-ready input and the not-ready input from the network processor. It can flush incoming words instead of storing them, and a reset bit clears the channel and pulses a reset to the transmit half.

Top module: `imp_rx_dma`

## Requirements
- R1: After the synchronous reset, control/status reads with only bit 7 (ready) set plus the status mirrors of R14. Address and count read 0, and `irq`, `relay_close` and `mem_req` are 0.
- R2: While ready, a write sets control bits 2 (relay, driven on `relay_close`), 3 (store enable), 5:4 (address bits 17:16) and 6 (interrupt enable), and loads the address (offset 4) and count (offset 6) registers. Writes to offset 2 are ignored.
- R3: While a transfer runs (bit 7 = 0, bit 0 reads 1), writes to any register are ignored, except for the reset bit.
- R4: A stored word is requested on `mem_req` with `mem_addr` = {bits 5:4, address register} and the word on `mem_wdata`. A successful acknowledge adds 4 to the 18-bit address, carrying into bits 5:4, and adds 1 to the count.
- R5: The transfer ends when the count becomes zero. Bit 0 then reads 0 and bit 7 reads 1.
- R6: Storing a word marked end-of-message ends the transfer and sets bit 13.
- R7: An error response ends the transfer and sets bits 14 and 15. Address and count do not advance.
- R8: A falling `host_rdy_in` during a transfer ends it, sets bits 9 and 15, and withdraws any pending request. A new start clears bits 9, 13 and 14.
- R9: With store enable clear, `net_ready` is 1 and arriving words are discarded. No memory request is made, and count and data buffer are unchanged.
- R10: With store enable set, `net_ready` is 0 while idle or while a word awaits memory. Bit 8 shows such a waiting word.
- R11: Reads of offset 2 return the last stored word's low half, then its high half, alternating. Each newly stored word restarts at the low half.
- R12: `irq` rises at the end of a transfer only if bit 6 was set. It stays high until the next control/status write.
- R13: Writing 1 to bit 1 clears the channel, drops `relay_close`, and pulses `xmit_reset` for one cycle.
- R14: Bit 11 mirrors `host_rdy_in` and bit 10 mirrors `imp_nrdy_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances data buffer half) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| net_valid | input | 1 | Network word offered |
| net_data | input | 32 | Network word |
| net_eom | input | 1 | Word is the last of its message |
| net_ready | output | 1 | Channel takes the offered word |
| host_rdy_in | input | 1 | Debounced host-ready line |
| imp_nrdy_in | input | 1 | Network processor not ready |
| relay_close | output | 1 | Closes the host-ready relay |
| xmit_reset | output | 1 | One-cycle reset to the transmit half |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | Memory response for the current request |
| mem_err | input | 1 | Response is a nonexistent-address error |

## Verification
The assertions check the handshake rules on every cycle. Flushing always offers `net_ready`, and a storing channel never offers it while idle or holding a word. A request holds steady until answered, and error responses and host-ready drops end the transfer. The interrupt only stands while idle, and the transmit-side reset pulse leaves the relay open. Only the bench scenarios can show the values that follow a transfer. These are the address carry into the extension bits, the count reaching zero, the status flag patterns, the alternating order of data buffer halves, and the fact that flushed or busy-time writes change nothing.

// File: rtl/imp_rx_pkg.sv
package imp_rx_pkg;
    localparam int REG_W  = 16;
    localparam int DATA_W = 32;
    localparam int EXT_W  = 2;

    // control/status bit positions
    localparam int B_GO    = 0;
    localparam int B_RST   = 1;
    localparam int B_RELAY = 2;
    localparam int B_STORE = 3;
    localparam int B_EXT   = 4;
    localparam int B_IE    = 6;
    localparam int B_RDY   = 7;
    localparam int B_IBF   = 8;
    localparam int B_MRE   = 9;
    localparam int B_INR   = 10;
    localparam int B_HR    = 11;
    localparam int B_EOM   = 13;
    localparam int B_NXM   = 14;
    localparam int B_ERR   = 15;

    typedef enum logic [1:0] {
        SEL_CSR  = 2'd0,
        SEL_DBUF = 2'd1,
        SEL_ADDR = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             ie;
        logic [EXT_W-1:0] ext;
        logic             store;
        logic             relay;
    } ctl_t;

    typedef struct packed {
        logic eom;
        logic nxm;
        logic mre;
    } flags_t;

    function automatic ctl_t ctl_from_word(input logic [REG_W-1:0] w);
        ctl_t c;
        c.ie    = w[B_IE];
        c.ext   = w[B_EXT +: EXT_W];
        c.store = w[B_STORE];
        c.relay = w[B_RELAY];
        return c;
    endfunction
endpackage

// File: rtl/imp_rx_mover.sv
module imp_rx_mover
    import imp_rx_pkg::*;
#(
    parameter int WORD_W = DATA_W,
    parameter int HALF_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              busy,
    input  logic              store_en,
    input  logic              net_valid,
    input  logic [WORD_W-1:0] net_data,
    input  logic              net_eom,
    output logic              net_ready,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              db_rd,
    output logic [HALF_W-1:0] db_half,
    output logic              word_done,
    output logic              word_fail,
    output logic              eom_held,
    output logic              ibf
);
    localparam int HALVES = WORD_W / HALF_W;
    localparam int HP_W   = (HALVES > 1) ? $clog2(HALVES) : 1;

    logic [WORD_W-1:0] buf_q;
    logic              ibf_q;
    logic              eom_q;
    logic [HP_W-1:0]   half_q;
    logic              take;

    assign net_ready = !store_en || (busy && !ibf_q);
    assign take      = net_valid && net_ready && store_en && busy;
    assign mem_req   = ibf_q && busy;
    assign mem_wdata = buf_q;
    assign word_done = mem_req && mem_ack && !mem_err;
    assign word_fail = mem_req && mem_ack && mem_err;
    assign eom_held  = eom_q;
    assign ibf       = ibf_q;

    // half selection: one slice per half, picked by the pointer
    logic [HALF_W-1:0] halves [HALVES];
    for (genvar g = 0; g < HALVES; g++) begin : g_half
        assign halves[g] = buf_q[g*HALF_W +: HALF_W];
    end
    assign db_half = halves[half_q];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            buf_q  <= '0;
            ibf_q  <= 1'b0;
            eom_q  <= 1'b0;
            half_q <= '0;
        end else begin
            if (take) begin
                buf_q  <= net_data;
                ibf_q  <= 1'b1;
                eom_q  <= net_eom;
                half_q <= '0;
            end else begin
                if (ibf_q && (mem_ack || !busy)) begin
                    ibf_q <= 1'b0;
                end
                if (db_rd) begin
                    half_q <= (half_q == HP_W'(HALVES - 1)) ? '0 : half_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/imp_rx_regs.sv
module imp_rx_regs
    import imp_rx_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int EW = EXT_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [RW-1:0]    reg_wdata,
    output logic [RW-1:0]    reg_rdata,
    input  logic             host_rdy_in,
    input  logic             imp_nrdy_in,
    input  logic             word_done,
    input  logic             word_fail,
    input  logic             eom_held,
    input  logic             ibf,
    input  logic [RW-1:0]    db_half,
    output ctl_t             ctl,
    output logic             busy,
    output logic             irq,
    output logic             xmit_reset,
    output logic [RW+EW-1:0] mem_addr
);
    localparam int AW   = RW + EW;
    localparam int STEP = DW / 8;

    reg_sel_e          sel;
    logic              sel_ok;
    logic              wr_csr;
    logic              rst_req;
    logic              can_wr;
    logic              mre_ev;
    logic              end_ev;
    logic [AW-1:0]     addr_next;
    logic [RW-1:0]     cnt_next;
    logic [RW-1:0]     csr_word;

    ctl_t              ctl_q;
    flags_t            flg_q;
    logic              busy_q;
    logic              irq_q;
    logic              xrst_q;
    logic              hr_q;
    logic [RW-1:0]     addr_q;
    logic [RW-1:0]     cnt_q;

    assign sel       = reg_sel_e'(reg_addr[2:1]);
    assign sel_ok    = !reg_addr[0];
    assign wr_csr    = reg_wr && sel_ok && (sel == SEL_CSR);
    assign rst_req   = wr_csr && reg_wdata[B_RST];
    assign can_wr    = reg_wr && sel_ok && !busy_q;
    assign mre_ev    = busy_q && hr_q && !host_rdy_in;
    assign addr_next = {ctl_q.ext, addr_q} + AW'(STEP);
    assign cnt_next  = cnt_q + 1'b1;

    always_comb begin
        end_ev = 1'b0;
        if (busy_q) begin
            end_ev = mre_ev || word_fail ||
                     (word_done && ((cnt_next == '0) || eom_held));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rst_req) begin
            ctl_q  <= '0;
            flg_q  <= '0;
            busy_q <= 1'b0;
            irq_q  <= 1'b0;
            addr_q <= '0;
            cnt_q  <= '0;
            hr_q   <= host_rdy_in;
            xrst_q <= rst_req && !rst;
        end else begin
            xrst_q <= 1'b0;
            hr_q   <= host_rdy_in;
            if (can_wr) begin
                unique case (sel)
                    SEL_CSR: begin
                        ctl_q <= ctl_from_word(reg_wdata);
                        irq_q <= 1'b0;
                        if (reg_wdata[B_GO]) begin
                            busy_q <= 1'b1;
                            flg_q  <= '0;
                        end
                    end
                    SEL_ADDR: addr_q <= reg_wdata;
                    SEL_CNT:  cnt_q  <= reg_wdata;
                    default: ;
                endcase
            end
            if (busy_q) begin
                if (mre_ev) begin
                    flg_q.mre <= 1'b1;
                end else if (word_fail) begin
                    flg_q.nxm <= 1'b1;
                end else if (word_done) begin
                    {ctl_q.ext, addr_q} <= addr_next;
                    cnt_q <= cnt_next;
                    if (eom_held) flg_q.eom <= 1'b1;
                end
                if (end_ev) begin
                    busy_q <= 1'b0;
                    irq_q  <= ctl_q.ie;
                end
            end
        end
    end

    always_comb begin
        csr_word                    = '0;
        csr_word[B_GO]              = busy_q;
        csr_word[B_RELAY]           = ctl_q.relay;
        csr_word[B_STORE]           = ctl_q.store;
        csr_word[B_EXT +: EW]       = ctl_q.ext;
        csr_word[B_IE]              = ctl_q.ie;
        csr_word[B_RDY]             = !busy_q;
        csr_word[B_IBF]             = ibf && busy_q;
        csr_word[B_MRE]             = flg_q.mre;
        csr_word[B_INR]             = imp_nrdy_in;
        csr_word[B_HR]              = host_rdy_in;
        csr_word[B_EOM]             = flg_q.eom;
        csr_word[B_NXM]             = flg_q.nxm;
        csr_word[B_ERR]             = flg_q.nxm || flg_q.mre;
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_ok) begin
            unique case (sel)
                SEL_CSR:  reg_rdata = csr_word;
                SEL_DBUF: reg_rdata = db_half;
                SEL_ADDR: reg_rdata = addr_q;
                SEL_CNT:  reg_rdata = cnt_q;
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign ctl        = ctl_q;
    assign busy       = busy_q;
    assign irq        = irq_q;
    assign xmit_reset = xrst_q;
    assign mem_addr   = {ctl_q.ext, addr_q};
endmodule

// File: rtl/imp_rx_dma.sv
module imp_rx_dma
    import imp_rx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              reg_addr,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    input  logic                    net_valid,
    input  logic [DATA_W-1:0]       net_data,
    input  logic                    net_eom,
    output logic                    net_ready,
    input  logic                    host_rdy_in,
    input  logic                    imp_nrdy_in,
    output logic                    relay_close,
    output logic                    xmit_reset,
    output logic                    irq,
    output logic                    mem_req,
    output logic [REG_W+EXT_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic                    mem_err
);
    ctl_t             ctl;
    logic             busy;
    logic             store_en;
    logic             ibf;
    logic             word_done;
    logic             word_fail;
    logic             eom_held;
    logic             db_rd;
    logic [REG_W-1:0] db_half;

    assign store_en    = ctl.store;
    assign relay_close = ctl.relay;
    assign db_rd       = reg_rd && !reg_addr[0] &&
                         (reg_sel_e'(reg_addr[2:1]) == SEL_DBUF);

    imp_rx_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .host_rdy_in(host_rdy_in),
        .imp_nrdy_in(imp_nrdy_in),
        .word_done  (word_done),
        .word_fail  (word_fail),
        .eom_held   (eom_held),
        .ibf        (ibf),
        .db_half    (db_half),
        .ctl        (ctl),
        .busy       (busy),
        .irq        (irq),
        .xmit_reset (xmit_reset),
        .mem_addr   (mem_addr)
    );

    imp_rx_mover u_mover (
        .clk       (clk),
        .rst       (rst),
        .clr       (xmit_reset),
        .busy      (busy),
        .store_en  (store_en),
        .net_valid (net_valid),
        .net_data  (net_data),
        .net_eom   (net_eom),
        .net_ready (net_ready),
        .mem_req   (mem_req),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .db_rd     (db_rd),
        .db_half   (db_half),
        .word_done (word_done),
        .word_fail (word_fail),
        .eom_held  (eom_held),
        .ibf       (ibf)
    );
endmodule

// File: rtl/imp_rx_dma_chk.sv
module imp_rx_dma_chk #(
    parameter int AW = 18,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          store_en,
    input logic          ibf,
    input logic          net_ready,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          host_rdy_in,
    input logic          reg_wr,
    input logic          irq,
    input logic          xmit_reset,
    input logic          relay_close
);
    a_r9_flush_always_ready: assert property (@(posedge clk) disable iff (rst)
        !store_en |-> net_ready);

    a_r10_held_word_blocks: assert property (@(posedge clk) disable iff (rst)
        (store_en && ibf) |-> !net_ready);

    a_r10_idle_blocks: assert property (@(posedge clk) disable iff (rst)
        (store_en && !busy) |-> !net_ready);

    a_r4_request_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && host_rdy_in && !reg_wr) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    a_r7_error_ends: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> !busy);

    a_r8_bounce_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && $fell(host_rdy_in)) |=> (!busy && !mem_req));

    a_r12_irq_idle_only: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

    a_r13_reset_opens_relay: assert property (@(posedge clk) disable iff (rst)
        xmit_reset |-> (!relay_close && !busy && !irq));
endmodule

bind imp_rx_dma imp_rx_dma_chk #(.AW(imp_rx_pkg::REG_W + imp_rx_pkg::EXT_W),
                                 .DW(imp_rx_pkg::DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .store_en   (store_en),
    .ibf        (ibf),
    .net_ready  (net_ready),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .host_rdy_in(host_rdy_in),
    .reg_wr     (reg_wr),
    .irq        (irq),
    .xmit_reset (xmit_reset),
    .relay_close(relay_close)
);

// File: tb/imp_rx_dma_bench.sv
`timescale 1ns/1ps
module imp_rx_dma_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        net_valid = 1'b0;
    logic [31:0] net_data = '0;
    logic        net_eom = 1'b0;
    logic        net_ready;
    logic        host_rdy_in = 1'b0;
    logic        imp_nrdy_in = 1'b1;
    logic        relay_close;
    logic        xmit_reset;
    logic        irq;
    logic        mem_req;
    logic [17:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    localparam logic [17:0] NXM_BASE = 18'h30000;
    logic [49:0] exp_q [$];

    always #2.5 clk = ~clk;

    imp_rx_dma u_imp_rx_dma (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .net_valid(net_valid), .net_data(net_data), .net_eom(net_eom),
        .net_ready(net_ready), .host_rdy_in(host_rdy_in),
        .imp_nrdy_in(imp_nrdy_in), .relay_close(relay_close),
        .xmit_reset(xmit_reset), .irq(irq), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_err(mem_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory model: answers every request at once, compares it to the expected store list
    always @(negedge clk) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
        if (mem_req) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected memory request", {14'd0, mem_addr}, 32'hFFFFFFFF);
            end else begin
                logic [49:0] e;
                e = exp_q.pop_front();
                chk("R4 request address", {14'd0, mem_addr}, {14'd0, e[49:32]});
                chk("R4 request data", mem_wdata, e[31:0]);
            end
            mem_ack = 1'b1;
            mem_err = (mem_addr >= NXM_BASE);
        end
    end

    task automatic wr(input logic [2:0] off, input logic [15:0] d);
        @(negedge clk);
        reg_addr = off; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, output logic [15:0] v);
        @(negedge clk);
        reg_addr = off; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(input logic [31:0] d, input logic e, input bit store,
                        input logic [17:0] a);
        if (store) exp_q.push_back({a, d});
        @(negedge clk);
        net_valid = 1'b1; net_data = d; net_eom = e;
        #1;
        while (!net_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        net_valid = 1'b0; net_eom = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R14 reset state
        rd(3'd0, v); chk("R1 R14 reset status", {16'd0, v}, 32'h0480);
        rd(3'd4, v); chk("R1 reset address", {16'd0, v}, 32'h0);
        rd(3'd6, v); chk("R1 reset count", {16'd0, v}, 32'h0);
        #1;
        chk("R1 reset irq/relay/req", {29'd0, irq, relay_close, mem_req}, 32'h0);

        // R9 flush with store enable clear
        chk("R9 flush ready", {31'd0, net_ready}, 32'h1);
        send(32'hDEAD_BEEF, 1'b0, 0, '0);
        send(32'h0F0F_0F0F, 1'b1, 0, '0);
        settle();
        rd(3'd6, v); chk("R9 count unchanged", {16'd0, v}, 32'h0);
        rd(3'd2, v); chk("R9 buffer unchanged", {16'd0, v}, 32'h0);

        // R2 control writes, R14 mirrors
        @(negedge clk);
        host_rdy_in = 1'b1; imp_nrdy_in = 1'b0;
        wr(3'd0, 16'h004C);
        rd(3'd0, v); chk("R2 R14 control readback", {16'd0, v}, 32'h08CC);
        chk("R2 relay drive", {31'd0, relay_close}, 32'h1);
        wr(3'd2, 16'h1234);
        rd(3'd2, v); chk("R2 buffer write ignored", {16'd0, v}, 32'h0);
        #1;
        chk("R10 idle store blocks", {31'd0, net_ready}, 32'h0);

        // transfer 1: extended address carry, count end
        wr(3'd0, 16'h005C);
        wr(3'd4, 16'hFFF8);
        wr(3'd6, 16'hFFFD);
        wr(3'd0, 16'h005D);
        wr(3'd6, 16'h0000);
        rd(3'd6, v); chk("R3 busy write ignored", {16'd0, v}, 32'hFFFD);
        rd(3'd0, v); chk("R3 busy status", {16'd0, v}, 32'h085D);
        send(32'h1111_2222, 1'b0, 1, 18'h1FFF8);
        send(32'h3333_4444, 1'b0, 1, 18'h1FFFC);
        send(32'hA5A5_5A5A, 1'b0, 1, 18'h20000);
        settle();
        rd(3'd0, v); chk("R5 R4 end status with carry", {16'd0, v}, 32'h08EC);
        rd(3'd4, v); chk("R4 address advanced", {16'd0, v}, 32'h0004);
        rd(3'd6, v); chk("R5 count zero", {16'd0, v}, 32'h0);
        chk("R12 irq raised", {31'd0, irq}, 32'h1);
        rd(3'd2, v); chk("R11 low half", {16'd0, v}, 32'h5A5A);
        rd(3'd2, v); chk("R11 high half", {16'd0, v}, 32'hA5A5);
        rd(3'd2, v); chk("R11 low again", {16'd0, v}, 32'h5A5A);

        // transfer 2: end of message
        wr(3'd4, 16'h0100);
        wr(3'd6, 16'hFFF6);
        wr(3'd0, 16'h004D);
        #1;
        chk("R12 irq cleared by write", {31'd0, irq}, 32'h0);
        send(32'h0BAD_F00D, 1'b0, 1, 18'h00100);
        send(32'hCAFE_0123, 1'b1, 1, 18'h00104);
        settle();
        rd(3'd0, v); chk("R6 end of message status", {16'd0, v}, 32'h28CC);
        rd(3'd4, v); chk("R6 address", {16'd0, v}, 32'h0108);
        rd(3'd6, v); chk("R6 count", {16'd0, v}, 32'hFFF8);
        rd(3'd2, v); chk("R11 new word restarts low", {16'd0, v}, 32'h0123);

        // transfer 3: nonexistent memory, interrupt disabled
        wr(3'd4, 16'h0000);
        wr(3'd6, 16'hFFFE);
        wr(3'd0, 16'h003D);
        send(32'h7777_8888, 1'b0, 1, 18'h30000);
        settle();
        rd(3'd0, v); chk("R7 error status", {16'd0, v}, 32'hC8BC);
        rd(3'd4, v); chk("R7 address held", {16'd0, v}, 32'h0000);
        rd(3'd6, v); chk("R7 count held", {16'd0, v}, 32'hFFFE);
        chk("R12 no irq without enable", {31'd0, irq}, 32'h0);

        // transfer 4: host-ready bounce
        wr(3'd4, 16'h0200);
        wr(3'd6, 16'hFFF0);
        wr(3'd0, 16'h004D);
        rd(3'd0, v); chk("R8 start clears flags", {16'd0, v}, 32'h084D);
        @(negedge clk);
        host_rdy_in = 1'b0;
        settle();
        rd(3'd0, v); chk("R8 bounce status", {16'd0, v}, 32'h82CC);
        chk("R8 bounce irq", {31'd0, irq}, 32'h1);

        // R13 reset bit during a transfer
        wr(3'd0, 16'h000D);
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = 16'h0002; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R13 transmit reset pulse", {31'd0, xmit_reset}, 32'h1);
        @(negedge clk);
        chk("R13 pulse ends", {31'd0, xmit_reset}, 32'h0);
        chk("R13 relay dropped", {31'd0, relay_close}, 32'h0);
        rd(3'd0, v); chk("R13 cleared status", {16'd0, v}, 32'h0080);
        rd(3'd6, v); chk("R13 cleared count", {16'd0, v}, 32'h0);
        rd(3'd2, v); chk("R13 cleared buffer", {16'd0, v}, 32'h0);

        chk("R4 all stores seen", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule